// File: doc/BRIEF.md
# DMA Channel Performance Monitor

This block watches the traffic of a multi-channel DMA controller with two independent monitor counters. Each counter is pointed at one DMA channel and keeps two counts for it: a DATA count of completed transfer beats and a STALL count of cycles in which the channel requested service but was not served. The DMA engine supplies one beat strobe and one request level for each channel. The monitor never drives anything back into the DMA engine.

Software configures the block through one 32-bit control register and reads results through four read-only count registers. For each counter, the control register holds a channel select, an enable, an overflow policy and a write-one clear strobe. The overflow policy decides what happens when a count is about to pass its maximum. In wrap mode both counts of that counter return to zero. In freeze mode the counter holds its values and then stays frozen until software clears it.

Top module: `dma_perf_mon`

## Requirements
- R1: After reset the control register reads 0x00000000, and all four count registers read 0.
- R2: The control register is at offset 0x800. The counter 1 channel select is in bits 29:24 and the counter 0 channel select is in bits 21:16. The freeze-mode bits are bit 5 (counter 1) and bit 4 (counter 0). The enable bits are bit 1 (counter 1) and bit 0 (counter 0). All other bits read 0 and ignore writes.
- R3: A write of 1 to bit 9 (counter 1) or bit 8 (counter 0) clears that counter's DATA, STALL and frozen state at the clock edge of the write. This holds even if an event arrives in the same cycle. Writing 0 to these bits has no effect, and both bits always read 0.
- R4: A counter whose enable bit is 0 holds both counts unchanged.
- R5: An enabled counter adds 1 to DATA in each cycle in which its selected channel's beat input is 1. It adds 1 to STALL in each cycle in which that channel's request is 1 and its beat is 0. A control write takes effect for counting from the following cycle.
- R6: A channel select value of NUM_CH or more gives the counter no events.
- R7: In wrap mode (freeze bit 0), an event that would carry DATA or STALL past 2^CNT_W-1 sets both counts of that counter to 0.
- R8: In freeze mode (freeze bit 1), an event that would carry DATA or STALL past its maximum leaves both counts unchanged and freezes the counter. A frozen counter does not change until its clear bit is written, and clearing or setting its enable does not unfreeze it.
- R9: The count registers read zero-extended: counter 0 DATA at 0x804, counter 0 STALL at 0x808, counter 1 DATA at 0x80C, counter 1 STALL at 0x810. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |
| ch_beat_i | input | NUM_CH | Per-channel transfer beat completed this cycle |
| ch_req_i | input | NUM_CH | Per-channel request pending this cycle |

## Verification
The following properties are checked on every cycle:
- A clear strobe leaves both counts at zero.
- A disabled counter holds its counts.
- A frozen counter stays frozen with stable counts until cleared.
- A DATA count only holds, steps by one or returns to zero.
- Reserved and strobe bits of the control register read zero.

Only the bench scenarios can show the rest. This covers the exact counting against the selected channel, the wrap and freeze outcomes at the maximum, freeze surviving a disable and re-enable, out-of-range selects, and the one-cycle delay between a control write and its effect. A reference model compares these at a 4-bit counter width.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int NUM_CNT = 2;
  localparam int SEL_W   = 6;
  localparam logic [11:0] CTRL_OFS = 12'h800;
  localparam logic [11:0] CNT_OFS  = 12'h804;
  localparam int CNT_STRIDE = 8;
  localparam logic [31:0] CTRL_USED_MASK = 32'h3F3F_0033;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             frz_mode;
    logic             en;
  } cnt_cfg_t;

  function automatic int sel_lsb(int k);
    return 16 + 8 * k;
  endfunction
  function automatic int clr_bit(int k);
    return 8 + k;
  endfunction
  function automatic int frz_bit(int k);
    return 4 + k;
  endfunction
endpackage

// File: rtl/perf_ctrl_regs.sv
module perf_ctrl_regs
  import perf_mon_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [31:0]               wdata_i,
  output cnt_cfg_t [NUM_CNT-1:0]    cfg_o,
  output logic [NUM_CNT-1:0]        clr_o,
  output logic [31:0]               rdata_o
);
  cnt_cfg_t [NUM_CNT-1:0] cfg_q;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cfg
    localparam int SL = sel_lsb(k);
    localparam int CB = clr_bit(k);
    localparam int FB = frz_bit(k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[k] <= '0;
      end else if (we_i) begin
        cfg_q[k].sel      <= wdata_i[SL +: SEL_W];
        cfg_q[k].frz_mode <= wdata_i[FB];
        cfg_q[k].en       <= wdata_i[k];
      end
    end

    // write-one strobe, never stored
    assign clr_o[k] = we_i & wdata_i[CB];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      rdata_o[sel_lsb(k) +: SEL_W] = cfg_q[k].sel;
      rdata_o[frz_bit(k)]          = cfg_q[k].frz_mode;
      rdata_o[k]                   = cfg_q[k].en;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
  import perf_mon_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NUM_CH-1:0] beat_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic              data_ev_o,
  output logic              stall_ev_o
);
  logic [NUM_CH-1:0] hit;

  // out-of-range select matches no channel
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      hit[c] = (sel_i == SEL_W'(c));
    end
  end

  assign data_ev_o  = |(hit & beat_i);
  assign stall_ev_o = |(hit & req_i & ~beat_i);
endmodule

// File: rtl/perf_cnt_unit.sv
module perf_cnt_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             frz_mode_i,
  input  logic             clr_i,
  input  logic             data_ev_i,
  input  logic             stall_ev_i,
  output logic [CNT_W-1:0] data_o,
  output logic [CNT_W-1:0] stall_o,
  output logic             frozen_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] data_q, stall_q;
  logic             frozen_q;
  logic             ovf;

  assign ovf = (data_ev_i & (data_q == CNT_MAX)) | (stall_ev_i & (stall_q == CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      stall_q  <= '0;
      frozen_q <= 1'b0;
    end else if (clr_i) begin
      data_q   <= '0;
      stall_q  <= '0;
      frozen_q <= 1'b0;
    end else if (en_i && !frozen_q) begin
      if (ovf) begin
        if (frz_mode_i) begin
          frozen_q <= 1'b1;
        end else begin
          data_q  <= '0;
          stall_q <= '0;
        end
      end else begin
        data_q  <= data_q + CNT_W'(data_ev_i);
        stall_q <= stall_q + CNT_W'(stall_ev_i);
      end
    end
  end

  assign data_o   = data_q;
  assign stall_o  = stall_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/dma_perf_mon.sv
module dma_perf_mon
  import perf_mon_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] ch_beat_i,
  input  logic [NUM_CH-1:0] ch_req_i
);
  cnt_cfg_t [NUM_CNT-1:0]              cfg;
  logic [NUM_CNT-1:0]                  cnt_clr, cnt_en, cnt_frz_mode, cnt_frozen;
  logic [NUM_CNT-1:0][CNT_W-1:0]       cnt_data, cnt_stall;
  logic [31:0]                         ctrl_rdata;
  logic                                ctrl_we;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_OFS));

  perf_ctrl_regs u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .clr_o   (cnt_clr),
    .rdata_o (ctrl_rdata)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic data_ev, stall_ev;

    assign cnt_en[k]       = cfg[k].en;
    assign cnt_frz_mode[k] = cfg[k].frz_mode;

    perf_evt_sel #(.NUM_CH(NUM_CH)) u_sel (
      .sel_i      (cfg[k].sel),
      .beat_i     (ch_beat_i),
      .req_i      (ch_req_i),
      .data_ev_o  (data_ev),
      .stall_ev_o (stall_ev)
    );

    perf_cnt_unit #(.CNT_W(CNT_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cnt_en[k]),
      .frz_mode_i (cnt_frz_mode[k]),
      .clr_i      (cnt_clr[k]),
      .data_ev_i  (data_ev),
      .stall_ev_i (stall_ev),
      .data_o     (cnt_data[k]),
      .stall_o    (cnt_stall[k]),
      .frozen_o   (cnt_frozen[k])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_OFS)) reg_rdata_o = ctrl_rdata;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr_i == ADDR_W'(CNT_OFS) + ADDR_W'(CNT_STRIDE * k))
        reg_rdata_o = 32'(cnt_data[k]);
      if (reg_addr_i == ADDR_W'(CNT_OFS) + ADDR_W'(CNT_STRIDE * k + 4))
        reg_rdata_o = 32'(cnt_stall[k]);
    end
  end
endmodule

// File: rtl/dma_perf_mon_chk.sv
module dma_perf_mon_chk
  import perf_mon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [31:0]                   reg_rdata_o,
  input logic [NUM_CNT-1:0]            cnt_clr,
  input logic [NUM_CNT-1:0]            cnt_en,
  input logic [NUM_CNT-1:0]            cnt_frozen,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_data,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_stall
);
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(CTRL_OFS)) |-> ((reg_rdata_o & ~CTRL_USED_MASK) == 32'd0));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_k
    a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_clr[k] |=> (cnt_data[k] == '0) && (cnt_stall[k] == '0) && !cnt_frozen[k]);

    a_r4_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_clr[k] && !cnt_en[k]) |=> $stable(cnt_data[k]) && $stable(cnt_stall[k]));

    a_r8_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_frozen[k] && !cnt_clr[k]) |=>
        cnt_frozen[k] && $stable(cnt_data[k]) && $stable(cnt_stall[k]));

    a_r5_data_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_clr[k] |=> (cnt_data[k] == $past(cnt_data[k])) ||
                      (cnt_data[k] == CNT_W'($past(cnt_data[k]) + 1'b1)) ||
                      (cnt_data[k] == '0));
  end
endmodule

bind dma_perf_mon dma_perf_mon_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .cnt_clr     (cnt_clr),
  .cnt_en      (cnt_en),
  .cnt_frozen  (cnt_frozen),
  .cnt_data    (cnt_data),
  .cnt_stall   (cnt_stall)
);

// File: tb/tb_dma_perf_mon.sv
`timescale 1ns/1ps
module tb_dma_perf_mon;
  localparam int NUM_CH = 16;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam logic [11:0] A_CTRL = 12'h800;

  logic clk = 0, rst_ni = 0;
  logic reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NUM_CH-1:0] beat = '0, req = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_sel[2], m_d[2], m_s[2];
  bit m_en[2], m_of[2], m_frz[2];

  always #2.5 clk = ~clk;

  dma_perf_mon #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(12)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ch_beat_i(beat), .ch_req_i(req)
  );

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] v = '0;
    if (a == A_CTRL) begin
      v[29:24] = 6'(m_sel[1]); v[21:16] = 6'(m_sel[0]);
      v[5] = m_of[1]; v[4] = m_of[0]; v[1] = m_en[1]; v[0] = m_en[0];
    end else if (a == 12'h804) v = 32'(m_d[0]);
    else if (a == 12'h808) v = 32'(m_s[0]);
    else if (a == 12'h80C) v = 32'(m_d[1]);
    else if (a == 12'h810) v = 32'(m_s[1]);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    reg_addr = a; #0.1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic check_all();
    reg_addr = A_CTRL;  #0.2; chk("R2 ctrl", reg_rdata, exp_read(A_CTRL));
    reg_addr = 12'h804; #0.2; chk("R5 data0", reg_rdata, exp_read(12'h804));
    reg_addr = 12'h808; #0.2; chk("R5 stall0", reg_rdata, exp_read(12'h808));
    reg_addr = 12'h80C; #0.2; chk("R5 data1", reg_rdata, exp_read(12'h80C));
    reg_addr = 12'h810; #0.2; chk("R5 stall1", reg_rdata, exp_read(12'h810));
  endtask

  // one clock: drive, predict, commit, compare
  task automatic step(logic we, logic [11:0] a, logic [31:0] wd,
                      logic [NUM_CH-1:0] bt, logic [NUM_CH-1:0] rq);
    int nd[2], ns[2]; bit nf[2];
    reg_we = we; reg_addr = a; reg_wdata = wd; beat = bt; req = rq;
    for (int k = 0; k < 2; k++) begin
      bit strobe, ed, es;
      strobe = we && (a == A_CTRL) && wd[8+k];
      ed = (m_sel[k] < NUM_CH) && bt[m_sel[k]];
      es = (m_sel[k] < NUM_CH) && rq[m_sel[k]] && !bt[m_sel[k]];
      nd[k] = m_d[k]; ns[k] = m_s[k]; nf[k] = m_frz[k];
      if (strobe) begin
        nd[k] = 0; ns[k] = 0; nf[k] = 0;
      end else if (m_en[k] && !m_frz[k]) begin
        if ((ed && m_d[k] == CMAX) || (es && m_s[k] == CMAX)) begin
          if (m_of[k]) nf[k] = 1;
          else begin nd[k] = 0; ns[k] = 0; end
        end else begin
          nd[k] = m_d[k] + int'(ed); ns[k] = m_s[k] + int'(es);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      m_d[k] = nd[k]; m_s[k] = ns[k]; m_frz[k] = nf[k];
    end
    if (we && a == A_CTRL) begin
      m_sel[1] = int'(wd[29:24]); m_sel[0] = int'(wd[21:16]);
      m_of[1] = wd[5]; m_of[0] = wd[4]; m_en[1] = wd[1]; m_en[0] = wd[0];
    end
    reg_we = 0;
    check_all();
  endtask

  function automatic logic [31:0] cfg(int s1, int s0, bit of1, bit of0, bit en1, bit en0,
                                      bit c1, bit c0);
    logic [31:0] v = '0;
    v[29:24] = 6'(s1); v[21:16] = 6'(s0); v[9] = c1; v[8] = c0;
    v[5] = of1; v[4] = of0; v[1] = en1; v[0] = en0;
    return v;
  endfunction

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_sel[k] = 0; m_d[k] = 0; m_s[k] = 0; m_en[k] = 0; m_of[k] = 0; m_frz[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #0.2;
    // R1 reset state
    rd_chk("R1 ctrl reset", A_CTRL, 32'h0);
    rd_chk("R1 data0 reset", 12'h804, 32'h0);
    rd_chk("R1 stall1 reset", 12'h810, 32'h0);

    // R2 all-ones write: reserved and strobe bits read 0
    step(1, A_CTRL, 32'hFFFF_FFFF, '0, '0);
    rd_chk("R2 ctrl all ones", A_CTRL, 32'h3F3F_0033);

    // counter0 ch3 wrap mode, counter1 ch7 freeze mode, both cleared
    step(1, A_CTRL, cfg(7, 3, 1, 0, 1, 1, 1, 1), '0, '0);
    for (int i = 0; i < 5; i++) step(0, 12'h0, 0, 16'h0008, 16'h0080);
    rd_chk("R5 data0 after 5 beats", 12'h804, 32'd5);
    rd_chk("R5 stall1 after 5 stalls", 12'h810, 32'd5);

    // R7 wrap: 10 more beats reach 15, one more wraps both to 0
    for (int i = 0; i < 10; i++) step(0, 12'h0, 0, 16'h0008, 16'h0000);
    rd_chk("R7 data0 at max", 12'h804, 32'd15);
    step(0, 12'h0, 0, 16'h0008, 16'h0000);
    rd_chk("R7 data0 wrapped", 12'h804, 32'd0);

    // R8 freeze: stall1 sits at 15
    for (int i = 0; i < 15; i++) step(0, 12'h0, 0, 16'h0000, 16'h0080);
    rd_chk("R8 stall1 frozen at max", 12'h810, 32'd15);
    step(0, 12'h0, 0, 16'h0080, 16'h0080);
    rd_chk("R8 data1 frozen", 12'h80C, 32'd0);
    // disable then re-enable counter1: still frozen
    step(1, A_CTRL, cfg(7, 3, 1, 0, 0, 1, 0, 0), '0, '0);
    step(1, A_CTRL, cfg(7, 3, 1, 0, 1, 1, 0, 0), '0, '0);
    for (int i = 0; i < 3; i++) step(0, 12'h0, 0, 16'h0080, 16'h0080);
    rd_chk("R8 frozen after re-enable", 12'h810, 32'd15);

    // R3 clear strobe with event in same cycle wins; zero bits no effect
    step(1, A_CTRL, cfg(7, 3, 1, 0, 1, 1, 1, 0), 16'h0080, 16'h0080);
    rd_chk("R3 clear beats event", 12'h80C, 32'd0);
    rd_chk("R3 stall1 cleared", 12'h810, 32'd0);
    step(0, 12'h0, 0, 16'h0080, 16'h0000);
    rd_chk("R3 counting resumes", 12'h80C, 32'd1);

    // R4 disabled counter0 ignores beats
    step(0, 12'h0, 0, 16'h0008, 16'h0000);
    step(1, A_CTRL, cfg(7, 3, 1, 0, 1, 0, 0, 0), 16'h0008, 16'h0000);
    for (int i = 0; i < 4; i++) step(0, 12'h0, 0, 16'h0008, 16'h0008);
    rd_chk("R4 data0 held", 12'h804, 32'd2);

    // R6 out-of-range select sees nothing
    step(1, A_CTRL, cfg(7, 40, 1, 0, 1, 1, 0, 0), '0, '0);
    for (int i = 0; i < 4; i++) step(0, 12'h0, 0, 16'hFFFF, 16'hFFFF);
    rd_chk("R6 data0 no events", 12'h804, 32'd2);

    // R9 unmapped offsets read 0
    rd_chk("R9 unmapped 0x814", 12'h814, 32'h0);
    rd_chk("R9 unmapped 0x000", 12'h000, 32'h0);

    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) begin
        int s0, s1;
        s0 = $urandom_range(19); s1 = $urandom_range(19);
        if (s1 == s0) s1 = (s0 + 1) % 20;
        step(1, A_CTRL,
             cfg(s1, s0, $urandom_range(1), $urandom_range(1),
                 $urandom_range(3) != 0, $urandom_range(3) != 0,
                 $urandom_range(7) == 0, $urandom_range(7) == 0),
             NUM_CH'($urandom), NUM_CH'($urandom));
      end else begin
        step(0, 12'(32'h804 + ($urandom_range(3) << 2)), $urandom,
             NUM_CH'($urandom), NUM_CH'($urandom));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule